// File: doc/BRIEF.md
# Compact Column-Serial AES-128 Encryption Core

This block encrypts one 128-bit block with AES-128 at a time and is sized for minimum logic, not throughput. Its datapath is 32 bits wide and builds the next state one column at a time. Each cycle it looks up one state byte in a 256-entry table held in synchronous on-chip memory. The table merges byte substitution and column mixing. Four lookups, each rotated into the lane of the byte's row, are XOR-combined to form one output column. Row shifting is done by registers: the state bytes are kept as four rotating row registers read at a fixed diagonal tap, and finished columns pass through a second, column-wide shift register.

The core holds no key expansion logic. A host expands the key in software and writes the 44 schedule words into an internal key store through a word-addressed write port. The host then raises `start` with the first plaintext column and presents the other three columns on the next three cycles. After a fixed latency the core returns the four ciphertext columns on consecutive cycles, and `done` marks the last of them.

Top module: `aes128_col_core`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `busy`, `dout_valid` and `done` are 0. Reset also aborts an encryption that is in progress.
- R2: When the core is idle, `start` high at a clock edge begins an encryption. `din` carries plaintext column 0 in that cycle and columns 1, 2 and 3 in the next three cycles. Each column word has row 0 in bits 31:24 and row 3 in bits 7:0, and the 128-bit block is read most significant word first.
- R3: A write with `key_wr_en` high stores `key_wr_data` at word `key_wr_addr`. Words 0 to 3 are added to the plaintext, and round n (1 to 10) uses words 4n to 4n+3. Writes to addresses 44 to 63 are ignored and leave words 0 to 43 unchanged.
- R4: The ciphertext equals the AES-128 encryption of the plaintext under the key whose schedule is in the key store.
- R5: `dout_valid` is high for exactly four consecutive cycles, which carry ciphertext columns 0 to 3 in order. The first of these is the 175th cycle after the edge that accepted `start`.
- R6: `done` is high for one cycle, and it coincides with the fourth ciphertext column.
- R7: `start` is ignored while `busy` is high, whether pulsed or held, with any `din` value. The running encryption keeps its result and its timing.
- R8: `busy` is high from the cycle after `start` is accepted through the cycle with `done`. The core accepts a new `start` in the very next cycle.
- R9: The key store keeps its contents across encryptions and across reset. Back-to-back encryptions with no rewrite give correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_wr_en | input | 1 | Key store write strobe |
| key_wr_addr | input | 6 | Key schedule word address |
| key_wr_data | input | 32 | Key schedule word |
| start | input | 1 | Begin an encryption (accepted only when idle) |
| din | input | 32 | Plaintext column word |
| busy | output | 1 | Encryption in progress |
| dout | output | 32 | Ciphertext column word |
| dout_valid | output | 1 | `dout` holds a ciphertext column |
| done | output | 1 | Last ciphertext column is on `dout` |

## Verification
The checker assumes that the host writes the key store only while `busy` is low. A write during an encryption would change round keys that are still being read. The bench loads each key schedule only between encryptions. It runs a reset and a deliberate `start` burst only while keys are not being written, and it places its out-of-range key writes while the core is idle. All other checked properties concern the core's own handshake: `start` taking effect, the shape of the output burst, and `busy` falling only after `done`.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOAD,
      ST_ROUND,
      ST_OUT
   } core_st_e;

   function automatic logic [7:0] gf_dbl(input logic [7:0] a);
      return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
   endfunction

   function automatic logic [7:0] gf_prod(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] acc;
      logic [7:0] sh;
      acc = 8'h00;
      sh  = a;
      for (int i = 0; i < 8; i++) begin
         if (b[i]) acc = acc ^ sh;
         sh = gf_dbl(sh);
      end
      return acc;
   endfunction

   // inverse as a^254 = a^2 * a^4 * ... * a^128
   function automatic logic [7:0] sub_byte(input logic [7:0] a);
      logic [7:0] sq;
      logic [7:0] inv;
      sq  = a;
      inv = 8'h01;
      for (int i = 1; i < 8; i++) begin
         sq  = gf_prod(sq, sq);
         inv = gf_prod(inv, sq);
      end
      return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                 ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
   endfunction

   // mixing contribution of a row-0 byte: rows {2s, s, s, 3s}
   function automatic logic [31:0] mix_entry(input logic [7:0] a);
      logic [7:0] s;
      s = sub_byte(a);
      return {gf_dbl(s), s, s, gf_dbl(s) ^ s};
   endfunction

endpackage

// File: rtl/aes_col_ttable.sv
module aes_col_ttable #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] addr,
   output logic [DATA_W-1:0] data
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W != 8 || DATA_W != 32) begin : g_bad_geom
         $error("aes_col_ttable: table must be 256 x 32");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = aes_col_pkg::mix_entry(8'(i));
   end

   always_ff @(posedge clk) data <= mem[addr];

endmodule

// File: rtl/aes_col_keystore.sv
module aes_col_keystore #(
   parameter int WORDS  = 44,
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   generate
      if ((1 << ADDR_W) < WORDS) begin : g_bad_addr
         $error("aes_col_keystore: address too narrow for depth");
      end
   endgenerate

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (wr_en && (32'(wr_addr) < WORDS)) mem[wr_addr] <= wr_data;
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/aes_col_accum.sv
module aes_col_accum #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [1:0]        row,
   input  logic              last,
   input  logic [DATA_W-1:0] tdata,
   input  logic [DATA_W-1:0] rkey,
   output logic [DATA_W-1:0] col_word
);
   generate
      if (DATA_W != 32) begin : g_bad_w
         $error("aes_col_accum: datapath must be 32 bits");
      end
   endgenerate

   logic [DATA_W-1:0] acc_q;
   logic [DATA_W-1:0] contrib;
   logic [7:0]        plain_s;

   assign plain_s = tdata[23:16];

   always_comb begin
      if (last) begin
         unique case (row)
            2'd0: contrib = {plain_s, 24'h0};
            2'd1: contrib = {8'h0, plain_s, 16'h0};
            2'd2: contrib = {16'h0, plain_s, 8'h0};
            default: contrib = {24'h0, plain_s};
         endcase
      end else begin
         unique case (row)
            2'd0: contrib = tdata;
            2'd1: contrib = {tdata[7:0], tdata[31:8]};
            2'd2: contrib = {tdata[15:0], tdata[31:16]};
            default: contrib = {tdata[23:0], tdata[31:24]};
         endcase
      end
   end

   assign col_word = ((row == 2'd0) ? '0 : acc_q) ^ contrib ^ rkey;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc_q <= '0;
      else if (en) acc_q <= (row == 2'd0) ? contrib : (acc_q ^ contrib);
   end

endmodule

// File: rtl/aes128_col_core.sv
module aes128_col_core #(
   parameter int DATA_W = 32,
   parameter int NR     = 10,
   parameter int KA_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr_en,
   input  logic [KA_W-1:0]   key_wr_addr,
   input  logic [DATA_W-1:0] key_wr_data,
   input  logic              start,
   input  logic [DATA_W-1:0] din,
   output logic              busy,
   output logic [DATA_W-1:0] dout,
   output logic              dout_valid,
   output logic              done
);
   import aes_col_pkg::*;

   localparam int COLS      = 4;
   localparam int ROWS      = 4;
   localparam int KEY_WORDS = COLS * (NR + 1);
   localparam int STEPS     = ROWS * COLS;
   localparam int STEP_W    = $clog2(STEPS + 1);
   localparam int RND_W     = $clog2(NR + 1);

   generate
      if (DATA_W != 32)            begin : g_bad_w   $error("core: 32-bit datapath only"); end
      if (NR != 10)                begin : g_bad_nr  $error("core: AES-128 needs 10 rounds"); end
      if (KA_W != RND_W + 2)       begin : g_bad_ka  $error("core: key address width mismatch"); end
      if (KA_W != $clog2(KEY_WORDS)) begin : g_bad_kd $error("core: key depth mismatch"); end
   endgenerate

   core_st_e                          st_q;
   logic [STEP_W-1:0]                 step_q;
   logic [RND_W-1:0]                  rnd_q;
   logic [DATA_W-1:0]                 din_q;
   logic [ROWS-1:0][COLS-1:0][7:0]    cur_q;   // rotating row registers
   logic [COLS-2:0][DATA_W-1:0]       nxt_q;   // finished-column shift register

   logic [KA_W-1:0]    key_raddr;
   logic [DATA_W-1:0]  key_rd;
   logic [7:0]         tab_addr;
   logic [DATA_W-1:0]  tab_data;
   logic [DATA_W-1:0]  col_word;
   logic [DATA_W-1:0]  load_word;
   logic [COLS-1:0][DATA_W-1:0] new_cols;
   logic [1:0]         row_sel;
   logic [1:0]         acc_row;
   logic               issue;
   logic               acc_en;
   logic               col_done;
   logic               round_end;
   logic               last_rnd;

   assign row_sel   = step_q[1:0];
   assign acc_row   = step_q[1:0] - 2'd1;
   assign issue     = (st_q == ST_ROUND) && (step_q < STEP_W'(STEPS));
   assign acc_en    = (st_q == ST_ROUND) && (step_q != '0);
   assign col_done  = acc_en && (step_q[1:0] == 2'd0);
   assign round_end = (st_q == ST_ROUND) && (step_q == STEP_W'(STEPS));
   assign last_rnd  = (rnd_q == RND_W'(NR));
   assign tab_addr  = cur_q[row_sel][row_sel];
   assign load_word = din_q ^ key_rd;
   assign new_cols  = {col_word, nxt_q[2], nxt_q[1], nxt_q[0]};

   always_comb begin
      key_raddr = '0;
      unique case (st_q)
         ST_LOAD:  key_raddr = KA_W'(step_q[1:0]) + KA_W'(1);
         ST_ROUND: if (step_q[1:0] == 2'd3) key_raddr = KA_W'({rnd_q, step_q[3:2]});
         default:  key_raddr = '0;
      endcase
   end

   aes_col_ttable #(.ADDR_W(8), .DATA_W(DATA_W)) u_tab (
      .clk  (clk),
      .addr (tab_addr),
      .data (tab_data)
   );

   aes_col_keystore #(.WORDS(KEY_WORDS), .ADDR_W(KA_W), .DATA_W(DATA_W)) u_keys (
      .clk     (clk),
      .wr_en   (key_wr_en),
      .wr_addr (key_wr_addr),
      .wr_data (key_wr_data),
      .rd_addr (key_raddr),
      .rd_data (key_rd)
   );

   aes_col_accum #(.DATA_W(DATA_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (acc_en),
      .row      (acc_row),
      .last     (last_rnd),
      .tdata    (tab_data),
      .rkey     (key_rd),
      .col_word (col_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         step_q <= '0;
         rnd_q  <= '0;
         din_q  <= '0;
         cur_q  <= '0;
         nxt_q  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  din_q  <= din;
                  step_q <= '0;
                  st_q   <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               for (int r = 0; r < ROWS; r++)
                  cur_q[r][step_q[1:0]] <= load_word[(ROWS-1-r)*8 +: 8];
               din_q <= din;
               if (step_q[1:0] == 2'd3) begin
                  st_q   <= ST_ROUND;
                  step_q <= '0;
                  rnd_q  <= RND_W'(1);
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            ST_ROUND: begin
               if (issue && row_sel == 2'd3) begin
                  for (int r = 0; r < ROWS; r++)
                     for (int c = 0; c < COLS; c++)
                        cur_q[r][c] <= cur_q[r][(c + 1) % COLS];
               end
               if (col_done && !round_end) begin
                  nxt_q[0] <= nxt_q[1];
                  nxt_q[1] <= nxt_q[2];
                  nxt_q[2] <= col_word;
               end
               if (round_end) begin
                  for (int r = 0; r < ROWS; r++)
                     for (int c = 0; c < COLS; c++)
                        cur_q[r][c] <= new_cols[c][(ROWS-1-r)*8 +: 8];
                  step_q <= '0;
                  if (last_rnd) st_q <= ST_OUT;
                  else          rnd_q <= rnd_q + 1'b1;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            ST_OUT: begin
               if (step_q[1:0] == 2'd3) begin
                  st_q   <= ST_IDLE;
                  step_q <= '0;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      dout = '0;
      for (int r = 0; r < ROWS; r++)
         dout[(ROWS-1-r)*8 +: 8] = cur_q[r][step_q[1:0]];
   end

   assign busy       = (st_q != ST_IDLE);
   assign dout_valid = (st_q == ST_OUT);
   assign done       = (st_q == ST_OUT) && (step_q[1:0] == 2'd3);

endmodule

// File: rtl/aes_col_core_chk.sv
module aes_col_core_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic dout_valid,
   input logic key_wr_en
);
   AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                  // R2

   AST_KEY_WR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      key_wr_en |-> !busy);                                        // R3

   AST_VALID_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_valid) |=> dout_valid);                           // R5

   AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      dout_valid |-> busy);                                        // R5

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                             // R6

   AST_DONE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> dout_valid);                                        // R6

   AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));                                // R8

   AST_START_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);                                   // R7

endmodule

bind aes128_col_core aes_col_core_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .dout_valid (dout_valid),
   .key_wr_en  (key_wr_en)
);

// File: tb/sim_aes128_col_core.sv
`timescale 1ns/1ps
module sim_aes128_col_core;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        key_wr_en;
   logic [5:0]  key_wr_addr;
   logic [31:0] key_wr_data;
   logic        start;
   logic [31:0] din;
   logic        busy;
   logic [31:0] dout;
   logic        dout_valid;
   logic        done;

   int checks = 0;
   int errors = 0;
   int wd     = 0;

   logic [7:0] sb [256];

   // {key, plaintext, ciphertext}
   localparam logic [383:0] VEC [3] = '{
      {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
       128'h3925841d02dc09fbdc118597196a0b32},
      {128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
       128'h69c4e0d86a7b0430d8cdb78070b4c55a},
      {128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
       128'h66e94bd4ef8a2c3b884cfa59ca342b2e}
   };

   always #2.5 clk = ~clk;

   aes128_col_core u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .key_wr_en   (key_wr_en),
      .key_wr_addr (key_wr_addr),
      .key_wr_data (key_wr_data),
      .start       (start),
      .din         (din),
      .busy        (busy),
      .dout        (dout),
      .dout_valid  (dout_valid),
      .done        (done)
   );

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", wd);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] tb_mul(input logic [7:0] a, input logic [7:0] b);
      logic [7:0] p = 8'h00;
      logic [7:0] x = a;
      logic [7:0] y = b;
      while (y != 0) begin
         if (y[0]) p ^= x;
         x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
         y = y >> 1;
      end
      return p;
   endfunction

   task automatic build_sbox();
      for (int a = 0; a < 256; a++) begin
         logic [7:0] inv = 8'h00;
         logic [7:0] s;
         for (int b = 1; b < 256; b++)
            if (a != 0 && tb_mul(8'(a), 8'(b)) == 8'h01) inv = 8'(b);
         for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                   ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 0;
         sb[a] = s;
      end
   endtask

   task automatic load_key(input logic [127:0] key);
      logic [31:0] w [44];
      logic [7:0]  rc = 8'h01;
      for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
      for (int i = 4; i < 44; i++) begin
         logic [31:0] t = w[i-1];
         if (i % 4 == 0) begin
            t = {sb[t[23:16]] ^ rc, sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]};
            rc = rc[7] ? ((rc << 1) ^ 8'h1b) : (rc << 1);
         end
         w[i] = w[i-4] ^ t;
      end
      for (int i = 0; i < 44; i++) begin
         key_wr_en = 1'b1; key_wr_addr = 6'(i); key_wr_data = w[i];
         @(negedge clk);
      end
      key_wr_en = 1'b0;
   endtask

   // called right after a negedge; returns right after a negedge
   task automatic run_enc(input logic [127:0] pt, input logic [127:0] exp_ct,
                          input string lbl, input bit hold);
      logic [127:0] got;
      int m;
      start = 1'b1; din = pt[127:96];
      @(negedge clk); start = 1'b0; din = pt[95:64];
      chk(busy === 1'b1, "R8", {lbl, " busy after start"}, 128'(busy), 128'd1);
      @(negedge clk); din = pt[63:32];
      @(negedge clk); din = pt[31:0];
      m = 3;
      while (dout_valid !== 1'b1 && m < 400) begin
         @(negedge clk);
         m++;
         if (hold && m >= 20 && m < 60) begin start = 1'b1; din = 32'hdead_beef ^ 32'(m); end
         else start = 1'b0;
      end
      start = 1'b0;
      chk(m == 175, hold ? "R7" : "R5", {lbl, " first valid cycle"}, 128'(m), 128'd175);
      for (int i = 0; i < 4; i++) begin
         if (i > 0) @(negedge clk);
         got[127-32*i -: 32] = dout;
         chk(dout_valid === 1'b1, "R5", {lbl, " valid run"}, 128'(dout_valid), 128'd1);
         chk(done === (i == 3), "R6", {lbl, " done position"}, 128'(done), 128'(i == 3));
      end
      chk(got === exp_ct, hold ? "R7" : "R4", {lbl, " ciphertext"}, got, exp_ct);
      @(negedge clk);
      chk(busy === 1'b0 && dout_valid === 1'b0, "R8", {lbl, " idle after done"},
          {busy, dout_valid}, 128'd0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; din = '0;
      key_wr_en = 1'b0; key_wr_addr = '0; key_wr_data = '0;
      build_sbox();
      repeat (3) @(negedge clk);
      chk({busy, dout_valid, done} === 3'b000, "R1", "outputs in reset",
          {busy, dout_valid, done}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, dout_valid, done} === 3'b000, "R1", "outputs after release",
          {busy, dout_valid, done}, 128'd0);

      // vector walk (R2, R4, R5, R6, R8)
      for (int v = 0; v < 3; v++) begin
         load_key(VEC[v][383:256]);
         run_enc(VEC[v][255:128], VEC[v][127:0], $sformatf("vec%0d", v), 1'b0);
      end

      // R9: back-to-back with no key rewrite, new start in the cycle after done
      run_enc(VEC[2][255:128], VEC[2][127:0], "r9_b2b_a", 1'b0);
      run_enc(VEC[2][255:128], VEC[2][127:0], "r9_b2b_b", 1'b0);

      // R7: start held and toggled with junk din during busy
      load_key(VEC[0][383:256]);
      run_enc(VEC[0][255:128], VEC[0][127:0], "r7_hold", 1'b1);

      // R3: writes above word 43 must not disturb the schedule
      for (int a = 44; a < 64; a++) begin
         key_wr_en = 1'b1; key_wr_addr = 6'(a); key_wr_data = 32'h5a5a_0000 | 32'(a);
         @(negedge clk);
      end
      key_wr_en = 1'b0;
      run_enc(VEC[0][255:128], VEC[0][127:0], "r3_high_addr", 1'b0);

      // R1 / R9: reset mid-run aborts, key store survives
      start = 1'b1; din = 32'h1111_1111;
      @(negedge clk); start = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({busy, dout_valid, done} === 3'b000, "R1", "abort by reset",
          {busy, dout_valid, done}, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_enc(VEC[0][255:128], VEC[0][127:0], "r9_after_reset", 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule